// File: doc/BRIEF.md
# LFSR-Counter Raster Timing Generator

This block produces horizontal sync, vertical sync, display-enable and a start-of-frame pulse for a raster display. Its horizontal and vertical position counters are 16-bit linear feedback shift registers rather than binary counters. Each step is a single shift plus a four-input XOR, so the logic stays shallow at any line length. Every compare point in the timing is therefore programmed as the LFSR state reached after the wanted number of steps from the all-ones seed, not as the step count itself.

Configuration arrives as index/data byte pairs, the format a upstream command decoder already emits. Sixteen-bit values span two consecutive indices. Most registers put the high byte at the lower index. The pixel-clock register is the one exception and puts the low byte first. The active pixel counts and the pixel-clock value are plain binary. They are not used for timing here and are passed on as configuration outputs to the pixel-fetch and clock-synthesis logic next door.

The horizontal counter steps every clock. When it reaches its line-end state it reloads the seed on the next clock and advances the vertical counter by one step. The vertical counter reloads the same way when it reaches its frame-end state.

Top module: `lfsr_raster_timing`

## Requirements
- R1: While reset is applied and after its release, until programmed otherwise, hsync, vsync, de and frame_start are low, and all configuration registers (so cfg_hpix, cfg_vpix, cfg_pclk) read zero. Both counters start at 0xFFFF.
- R2: Each counter advances by shifting left one bit, with new bit 0 equal to bit15 XOR bit4 XOR bit2 XOR bit1. A compare value that stands for N steps is the state reached after N such shifts from 0xFFFF.
- R3: When the horizontal state equals the line-end value (high byte index 0x09, low 0x0A), the counter reloads 0xFFFF on the next clock and the vertical counter takes one step. A line-end value of N steps gives a line of N+1 clocks. The vertical counter holds in all other clocks.
- R4: When the vertical state equals the frame-end value (0x11/0x12) at a line end, it reloads 0xFFFF. A frame-end value of M steps gives M+1 lines per frame.
- R5: hsync is high for horizontal positions from the hsync-on match (0x0B/0x0C) up to, not including, the hsync-off match (0x0D/0x0E).
- R6: vsync is high for line positions from the vsync-on match (0x13/0x14) up to, not including, the vsync-off match (0x15/0x16).
- R7: de is high only when the horizontal position lies in [column-start 0x01/0x02, column-stop 0x03/0x04) and the line position lies in [row-start 0x05/0x06, row-stop 0x07/0x08).
- R8: frame_start is high for exactly the first clock of each frame, the clock in which both counters hold 0xFFFF after reloading together.
- R9: A 16-bit register at index r takes its high byte from a write at r and its low byte from a write at r+1. A single byte write changes only that byte and is visible on the next clock.
- R10: The pixel-clock register (5 kHz units) takes its low byte at index 0x1B and its high byte at 0x1C, and is presented on cfg_pclk.
- R11: The active-width count (0x0F/0x10) and the active-height count (0x17/0x18) are plain binary and are presented on cfg_hpix and cfg_vpix.
- R12: A write to any index not named above changes no register and no timing output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe |
| wr_index | input | 8 | Register byte index |
| wr_data | input | 8 | Register byte value |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |
| frame_start | output | 1 | One-clock pulse on the first clock of a frame |
| cfg_hpix | output | 16 | Active width count, binary |
| cfg_vpix | output | 16 | Active height count, binary |
| cfg_pclk | output | 16 | Pixel clock in 5 kHz units |

## Verification
A horizontal counter off its sequence shows up within one line, as an hsync or de edge in the wrong clock or a line of the wrong length. A vertical counter that steps at the wrong time moves vsync and the frame_start spacing within one frame. A sync or display window flag that is set or cleared on the wrong match stretches or clips a pulse at the very next position where it should change. A byte-lane or index decode error shows on the configuration outputs one clock after the write, or as a timing shift in the next frame.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  localparam int LFSR_W = 16;
  localparam int BYTE_W = LFSR_W / 2;
  localparam int IDX_W  = 8;

  localparam logic [LFSR_W-1:0] SEED = '1;
  // feedback taps: bits 15, 4, 2, 1
  localparam logic [LFSR_W-1:0] TAPS = 16'h8016;

  // byte indices: high byte at index, low byte at index+1 (pixel clock reversed)
  localparam logic [IDX_W-1:0] IX_COL_ON  = 8'h01;
  localparam logic [IDX_W-1:0] IX_COL_OFF = 8'h03;
  localparam logic [IDX_W-1:0] IX_ROW_ON  = 8'h05;
  localparam logic [IDX_W-1:0] IX_ROW_OFF = 8'h07;
  localparam logic [IDX_W-1:0] IX_LINE_END = 8'h09;
  localparam logic [IDX_W-1:0] IX_HS_ON   = 8'h0B;
  localparam logic [IDX_W-1:0] IX_HS_OFF  = 8'h0D;
  localparam logic [IDX_W-1:0] IX_WIDTH   = 8'h0F;
  localparam logic [IDX_W-1:0] IX_FRAME_END = 8'h11;
  localparam logic [IDX_W-1:0] IX_VS_ON   = 8'h13;
  localparam logic [IDX_W-1:0] IX_VS_OFF  = 8'h15;
  localparam logic [IDX_W-1:0] IX_HEIGHT  = 8'h17;
  localparam logic [IDX_W-1:0] IX_PCLK    = 8'h1B;

  typedef logic [LFSR_W-1:0] word_t;

  typedef struct packed {
    word_t col_on;
    word_t col_off;
    word_t row_on;
    word_t row_off;
    word_t line_end;
    word_t hs_on;
    word_t hs_off;
    word_t width;
    word_t frame_end;
    word_t vs_on;
    word_t vs_off;
    word_t height;
    word_t pclk;
  } cfg_t;

  function automatic word_t lfsr_next(word_t s);
    return {s[LFSR_W-2:0], ^(s & TAPS)};
  endfunction
endpackage

// File: rtl/lrt_regfile.sv
module lrt_regfile
  import lrt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [BYTE_W-1:0] wr_data,
  output cfg_t              cfg
);
  localparam logic [IDX_W-1:0] ONE = 1;

  cfg_t cfg_q;
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    case (wr_index)
      IX_COL_ON:            cfg_d.col_on[LFSR_W-1:BYTE_W]    = wr_data;
      IX_COL_ON + ONE:      cfg_d.col_on[BYTE_W-1:0]         = wr_data;
      IX_COL_OFF:           cfg_d.col_off[LFSR_W-1:BYTE_W]   = wr_data;
      IX_COL_OFF + ONE:     cfg_d.col_off[BYTE_W-1:0]        = wr_data;
      IX_ROW_ON:            cfg_d.row_on[LFSR_W-1:BYTE_W]    = wr_data;
      IX_ROW_ON + ONE:      cfg_d.row_on[BYTE_W-1:0]         = wr_data;
      IX_ROW_OFF:           cfg_d.row_off[LFSR_W-1:BYTE_W]   = wr_data;
      IX_ROW_OFF + ONE:     cfg_d.row_off[BYTE_W-1:0]        = wr_data;
      IX_LINE_END:          cfg_d.line_end[LFSR_W-1:BYTE_W]  = wr_data;
      IX_LINE_END + ONE:    cfg_d.line_end[BYTE_W-1:0]       = wr_data;
      IX_HS_ON:             cfg_d.hs_on[LFSR_W-1:BYTE_W]     = wr_data;
      IX_HS_ON + ONE:       cfg_d.hs_on[BYTE_W-1:0]          = wr_data;
      IX_HS_OFF:            cfg_d.hs_off[LFSR_W-1:BYTE_W]    = wr_data;
      IX_HS_OFF + ONE:      cfg_d.hs_off[BYTE_W-1:0]         = wr_data;
      IX_WIDTH:             cfg_d.width[LFSR_W-1:BYTE_W]     = wr_data;
      IX_WIDTH + ONE:       cfg_d.width[BYTE_W-1:0]          = wr_data;
      IX_FRAME_END:         cfg_d.frame_end[LFSR_W-1:BYTE_W] = wr_data;
      IX_FRAME_END + ONE:   cfg_d.frame_end[BYTE_W-1:0]      = wr_data;
      IX_VS_ON:             cfg_d.vs_on[LFSR_W-1:BYTE_W]     = wr_data;
      IX_VS_ON + ONE:       cfg_d.vs_on[BYTE_W-1:0]          = wr_data;
      IX_VS_OFF:            cfg_d.vs_off[LFSR_W-1:BYTE_W]    = wr_data;
      IX_VS_OFF + ONE:      cfg_d.vs_off[BYTE_W-1:0]         = wr_data;
      IX_HEIGHT:            cfg_d.height[LFSR_W-1:BYTE_W]    = wr_data;
      IX_HEIGHT + ONE:      cfg_d.height[BYTE_W-1:0]         = wr_data;
      // pixel clock: low byte first
      IX_PCLK:              cfg_d.pclk[BYTE_W-1:0]           = wr_data;
      IX_PCLK + ONE:        cfg_d.pclk[LFSR_W-1:BYTE_W]      = wr_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/lrt_window.sv
module lrt_window #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] state,
  input  logic [W-1:0] on_val,
  input  logic [W-1:0] off_val,
  output logic         active
);
  logic hit_on;
  logic hit_off;
  logic flag_q;
  logic flag_d;

  always_comb begin
    hit_on  = (state == on_val);
    hit_off = (state == off_val);
    // on-match wins; off-match ends the window at this position
    active  = hit_on | (flag_q & ~hit_off);
    flag_d  = active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (step) begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/lrt_axis.sv
module lrt_axis
  import lrt_pkg::*;
#(
  parameter int NWIN = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         step,
  input  logic [LFSR_W-1:0]            end_val,
  input  logic [NWIN-1:0][LFSR_W-1:0]  win_on,
  input  logic [NWIN-1:0][LFSR_W-1:0]  win_off,
  output logic [LFSR_W-1:0]            state,
  output logic                         at_end,
  output logic [NWIN-1:0]              win_active
);
  word_t state_q;
  word_t state_d;

  always_comb begin
    at_end  = (state_q == end_val);
    state_d = at_end ? SEED : lfsr_next(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (step) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    lrt_window #(.W(LFSR_W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .state   (state_q),
      .on_val  (win_on[gi]),
      .off_val (win_off[gi]),
      .active  (win_active[gi])
    );
  end
endmodule

// File: rtl/lfsr_raster_timing.sv
module lfsr_raster_timing
  import lrt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              frame_start,
  output logic [LFSR_W-1:0] cfg_hpix,
  output logic [LFSR_W-1:0] cfg_vpix,
  output logic [LFSR_W-1:0] cfg_pclk
);
  localparam int NWIN    = 2;
  localparam int WIN_SYN = 0;
  localparam int WIN_DSP = 1;

  // reset: asserted asynchronously, released on clk
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  cfg_t cfg;

  lrt_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_index (wr_index),
    .wr_data  (wr_data),
    .cfg      (cfg)
  );

  word_t h_state, v_state;
  word_t line_end, frame_end, hs_on, hs_off, vs_on, vs_off, col_on, col_off;
  logic  h_at_end, v_at_end;
  logic [NWIN-1:0] h_win, v_win;
  logic [NWIN-1:0][LFSR_W-1:0] h_on, h_off, v_on, v_off;

  always_comb begin
    line_end  = cfg.line_end;
    frame_end = cfg.frame_end;
    hs_on     = cfg.hs_on;
    hs_off    = cfg.hs_off;
    vs_on     = cfg.vs_on;
    vs_off    = cfg.vs_off;
    col_on    = cfg.col_on;
    col_off   = cfg.col_off;
    h_on[WIN_SYN]  = cfg.hs_on;
    h_off[WIN_SYN] = cfg.hs_off;
    h_on[WIN_DSP]  = cfg.col_on;
    h_off[WIN_DSP] = cfg.col_off;
    v_on[WIN_SYN]  = cfg.vs_on;
    v_off[WIN_SYN] = cfg.vs_off;
    v_on[WIN_DSP]  = cfg.row_on;
    v_off[WIN_DSP] = cfg.row_off;
  end

  lrt_axis #(.NWIN(NWIN)) u_hax (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step       (1'b1),
    .end_val    (line_end),
    .win_on     (h_on),
    .win_off    (h_off),
    .state      (h_state),
    .at_end     (h_at_end),
    .win_active (h_win)
  );

  lrt_axis #(.NWIN(NWIN)) u_vax (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step       (h_at_end),
    .end_val    (frame_end),
    .win_on     (v_on),
    .win_off    (v_off),
    .state      (v_state),
    .at_end     (v_at_end),
    .win_active (v_win)
  );

  logic fs_q;
  logic fs_d;

  always_comb begin
    fs_d = h_at_end & v_at_end;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fs_q <= 1'b0;
    end else begin
      fs_q <= fs_d;
    end
  end

  assign hsync       = h_win[WIN_SYN];
  assign vsync       = v_win[WIN_SYN];
  assign de          = h_win[WIN_DSP] & v_win[WIN_DSP];
  assign frame_start = fs_q;
  assign cfg_hpix    = cfg.width;
  assign cfg_vpix    = cfg.height;
  assign cfg_pclk    = cfg.pclk;
endmodule

// File: rtl/lrt_checker.sv
module lrt_checker
  import lrt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [LFSR_W-1:0] h_state,
  input logic [LFSR_W-1:0] v_state,
  input logic [LFSR_W-1:0] line_end,
  input logic [LFSR_W-1:0] frame_end,
  input logic [LFSR_W-1:0] hs_on,
  input logic [LFSR_W-1:0] hs_off,
  input logic [LFSR_W-1:0] vs_on,
  input logic [LFSR_W-1:0] vs_off,
  input logic [LFSR_W-1:0] col_on,
  input logic [LFSR_W-1:0] col_off,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic              frame_start,
  input logic              wr_en,
  input logic [LFSR_W-1:0] cfg_hpix,
  input logic [LFSR_W-1:0] cfg_pclk
);
  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_state != line_end) |=> (h_state == lfsr_next($past(h_state)))); // R2
  AST_H_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (h_state == line_end) |=> (h_state == SEED)); // R3
  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (h_state != line_end) |=> $stable(v_state)); // R3
  AST_V_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (h_state == line_end && v_state == frame_end) |=> (v_state == SEED)); // R4
  AST_HSYNC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (h_state == hs_on) |-> hsync); // R5
  AST_HSYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (h_state == hs_off && h_state != hs_on) |-> !hsync); // R5
  AST_VSYNC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (v_state == vs_on) |-> vsync); // R6
  AST_VSYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (v_state == vs_off && v_state != vs_on) |-> !vsync); // R6
  AST_DE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (h_state == col_off && h_state != col_on) |-> !de); // R7
  AST_FRAME_POS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (h_state == SEED && v_state == SEED)); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cfg_hpix) && $stable(cfg_pclk))); // R9
endmodule

bind lfsr_raster_timing lrt_checker u_lrt_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .h_state     (h_state),
  .v_state     (v_state),
  .line_end    (line_end),
  .frame_end   (frame_end),
  .hs_on       (hs_on),
  .hs_off      (hs_off),
  .vs_on       (vs_on),
  .vs_off      (vs_off),
  .col_on      (col_on),
  .col_off     (col_off),
  .hsync       (hsync),
  .vsync       (vsync),
  .de          (de),
  .frame_start (frame_start),
  .wr_en       (wr_en),
  .cfg_hpix    (cfg_hpix),
  .cfg_pclk    (cfg_pclk)
);

// File: tb/lfsr_raster_timing_bench.sv
`timescale 1ns/1ps
module lfsr_raster_timing_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_index;
  logic [7:0]  wr_data;
  logic        hsync, vsync, de, frame_start;
  logic [15:0] cfg_hpix, cfg_vpix, cfg_pclk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam int LINE  = 10;  // line-end programmed at 9 steps
  localparam int LINES = 6;   // frame-end programmed at 5 steps

  always #2.5 clk = ~clk;

  lfsr_raster_timing u_lfsr_raster_timing (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_index (wr_index),
    .wr_data (wr_data), .hsync (hsync), .vsync (vsync), .de (de),
    .frame_start (frame_start), .cfg_hpix (cfg_hpix), .cfg_vpix (cfg_vpix),
    .cfg_pclk (cfg_pclk)
  );

  // R2: state after n steps from all ones
  function automatic logic [15:0] lf(int n);
    logic [15:0] v = 16'hFFFF;
    for (int i = 0; i < n; i++) v = {v[14:0], v[15] ^ v[4] ^ v[2] ^ v[1]};
    return v;
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] idx, logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_index = idx; wr_data = val;
    @(posedge clk);
  endtask

  task automatic wr_idle();
    @(negedge clk);
    wr_en = 1'b0; wr_index = 8'h00; wr_data = 8'h00;
  endtask

  task automatic wr16(logic [7:0] idx, logic [15:0] val);
    wr(idx, val[15:8]);
    wr(idx + 8'd1, val[7:0]);
  endtask

  task automatic wait_fs(output bit found);
    found = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (frame_start) begin found = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_index = 8'h00; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "hsync in reset", {15'd0, hsync}, 16'd0);
    chk("R1", "vsync in reset", {15'd0, vsync}, 16'd0);
    chk("R1", "de in reset", {15'd0, de}, 16'd0);
    chk("R1", "frame_start in reset", {15'd0, frame_start}, 16'd0);
    chk("R1", "cfg_hpix in reset", cfg_hpix, 16'd0);
    chk("R1", "cfg_pclk in reset", cfg_pclk, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    chk("R1", "hsync after release", {15'd0, hsync}, 16'd0);
  endtask

  // line end first so counters align before the first line wraps
  task automatic t_program();
    wr16(8'h09, lf(LINE - 1));   // R3 line end
    wr16(8'h11, lf(LINES - 1));  // R4 frame end
    wr16(8'h0B, lf(1));          // R5 hsync on
    wr16(8'h0D, lf(3));          // R5 hsync off
    wr16(8'h13, lf(0));          // R6 vsync on
    wr16(8'h15, lf(1));          // R6 vsync off
    wr16(8'h01, lf(2));          // R7 column window
    wr16(8'h03, lf(8));
    wr16(8'h05, lf(1));          // R7 row window
    wr16(8'h07, lf(4));
    wr_idle();
  endtask

  task automatic t_byte_order();
    wr(8'h0F, 8'h12); wr(8'h10, 8'h34);
    wr(8'h17, 8'hAB); wr(8'h18, 8'hCD);
    wr(8'h1B, 8'h78); wr(8'h1C, 8'h56);
    wr_idle();
    chk("R11", "cfg_hpix binary hi/lo", cfg_hpix, 16'h1234);
    chk("R11", "cfg_vpix binary hi/lo", cfg_vpix, 16'hABCD);
    chk("R10", "cfg_pclk low byte first", cfg_pclk, 16'h5678);
    wr(8'h10, 8'h99);
    wr_idle();
    chk("R9", "single low byte write", cfg_hpix, 16'h1299);
    wr(8'h17, 8'h0E);
    wr_idle();
    chk("R9", "single high byte write", cfg_vpix, 16'h0ECD);
  endtask

  task automatic t_frame(string tag, int hs_a, int hs_b);
    bit found;
    wait_fs(found);  // let any partly programmed line settle
    wait_fs(found);
    chk("R8", {tag, " frame_start seen"}, {15'd0, found}, 16'd1);
    for (int c = 0; c < LINE * LINES; c++) begin
      int hn = c % LINE;
      int vn = c / LINE;
      logic e_hs = (hn >= hs_a) && (hn < hs_b);
      logic e_vs = (vn == 0);
      logic e_de = (hn >= 2) && (hn < 8) && (vn >= 1) && (vn < 4);
      logic e_fs = (c == 0);
      chk("R5", {tag, " hsync"}, {15'd0, hsync}, {15'd0, e_hs});
      chk("R6", {tag, " vsync"}, {15'd0, vsync}, {15'd0, e_vs});
      chk("R7", {tag, " de"}, {15'd0, de}, {15'd0, e_de});
      chk("R8", {tag, " frame_start"}, {15'd0, frame_start}, {15'd0, e_fs});
      @(negedge clk);
    end
    chk("R8", {tag, " next frame_start"}, {15'd0, frame_start}, 16'd1);
  endtask

  task automatic t_period();
    bit found;
    int n = 0;
    wait_fs(found);
    do begin
      @(negedge clk);
      n++;
    end while (!frame_start && n < 4000);
    // R3 line of 10 clocks, R4 frame of 6 lines
    chk("R4", "frame period clocks", n[15:0], 16'(LINE * LINES));
  endtask

  task automatic t_reprogram();
    wr16(8'h0B, lf(4));
    wr16(8'h0D, lf(7));
    wr_idle();
    t_frame("moved hsync", 4, 7);
  endtask

  task automatic t_ignored();
    wr(8'h00, 8'hA5); wr(8'h1A, 8'hA5); wr(8'h1D, 8'hA5);
    wr(8'h40, 8'hA5); wr(8'hFF, 8'h00);
    wr_idle();
    chk("R12", "cfg_hpix after stray writes", cfg_hpix, 16'h1299);
    chk("R12", "cfg_vpix after stray writes", cfg_vpix, 16'h0ECD);
    chk("R12", "cfg_pclk after stray writes", cfg_pclk, 16'h5678);
    t_frame("stray writes", 4, 7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_program();
    t_byte_order();
    t_frame("base", 1, 3);
    t_period();
    t_reprogram();
    t_ignored();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule